// File: doc/BRIEF.md
# Protected-Write System Clock Prescaler

This block turns a free-running master clock into a divided system timing reference. It does not gate or regenerate a clock. It emits a one-cycle enable strobe `sys_en` that marks the last master cycle of each divided period, and synchronous logic downstream advances only on that strobe. The division is a power of two, from 1 to 256, chosen by a 4-bit select code held in an 8-bit control register.

Software cannot change the setting with a single store. It must first open a short unlock window by writing the unlock key (bit 7 set, all other bits clear). It then writes the new code, with bit 7 clear, within four master cycles. A two-state machine runs the window. In state LOCKED the only transition is *arm* (a key write), which moves it to ARMED. In ARMED the transitions are *re-arm* (another key write, which restarts the count), *commit* (a legal code is stored and the machine returns to LOCKED), *reject* (a reserved code is dropped and the machine returns to LOCKED) and *expire* (the fourth cycle passes with no select write, and the machine returns to LOCKED). A strap input picks the setting at reset.

A committed code does not change the strobe at once. The divider finishes the period it is in with the old factor and starts the next period with the new one. No period is ever cut short or stretched beyond the old or the new length.

Top module: `sysclk_prescaler`

## Requirements
- R1: While reset is asserted and just after it is released, the select field reads 0 (divide by 1) when `strap_div8` is low and 3 (divide by 8) when it is high, and bit 7 reads 0.
- R2: With select code k in 0..8 in effect, `sys_en` is high for exactly one master cycle in every 2^k cycles. With code 0 it stays high continuously.
- R3: Read data bits 6:4 always read 0, whatever was written to them. Bit 7 reads 1 exactly while an unlock window is open. Bits 3:0 read the stored select code.
- R4: A write of exactly 0x80 while locked opens the window, and bit 7 reads 1 from the cycle after that write.
- R5: Counting the arming write as cycle 0, a write with bit 7 clear and a code of 0..8 in bits 3:0, made in cycles 1 to 4, stores the code and closes the window. Bits 6:4 of that write are ignored.
- R6: If no select write arrives by cycle 4, the window closes and bit 7 reads 0 from cycle 5. A select write in cycle 5 or later leaves the select field unchanged.
- R7: While locked, any write other than 0x80, including values with bit 7 set and other bits set, leaves both the select field and bit 7 unchanged.
- R8: A write with bit 7 clear and a reserved code (9..15) during an open window is dropped. The select field keeps its value and the window closes.
- R9: A newly stored code takes effect at the end of the divided period in progress. The strobe gap that spans the change equals the old factor, and the following gaps equal the new factor.
- R10: Once unlocked, any code 0..8 can be stored whatever the strap level, including code 0 after a strap reset.
- R11: A write of 0x80 during an open window restarts the four-cycle count, with the rewrite as the new cycle 0. A write with bit 7 set and any other bits set leaves the window and its count untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_div8 | input | 1 | Reset strap: high selects divide by 8 at reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data: bit 7 window open, bits 6:4 zero, bits 3:0 select |
| sys_en | output | 1 | Divided-clock enable strobe |

## Verification
A window state stuck open or closed shows on read bit 7 in the cycle after the arming write. A wrong count shows when a select write in cycle 4 or 5 is accepted or refused against its rule. A select register that a locked or reserved write has disturbed shows on bits 3:0 one cycle after that write. A divider that switches mid-period, or holds a wrong count, shows as a strobe gap that differs from both the old and the new factor, within one old period after the commit. The reference model predicts read data and strobe on every master cycle, so any such fault is caught in the first cycle it appears.

// File: rtl/sysclk_prescaler_pkg.sv
package sysclk_prescaler_pkg;

    localparam int REG_W  = 8;
    localparam int SEL_W  = 4;
    localparam int EN_BIT = REG_W - 1;
    localparam logic [REG_W-1:0] ARM_KEY = 8'h80;

    typedef enum logic {
        ST_LOCKED = 1'b0,
        ST_ARMED  = 1'b1
    } unlock_state_e;

endpackage

// File: rtl/psc_unlock_fsm.sv
module psc_unlock_fsm
    import sysclk_prescaler_pkg::*;
#(
    parameter int MAX_CODE   = 8,
    parameter int WIN        = 4,
    parameter int STRAP_CODE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_div8,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic             window_open,
    output logic [SEL_W-1:0] sel_q
);

    localparam int WCW = (WIN > 1) ? $clog2(WIN) : 1;
    localparam logic [WCW-1:0]   LAST_CYC = WCW'(WIN - 1);
    localparam logic [SEL_W-1:0] CODE_MAX = SEL_W'(MAX_CODE);
    localparam logic [SEL_W-1:0] CODE_STR = SEL_W'(STRAP_CODE);

    unlock_state_e    state_q, state_d;
    logic [WCW-1:0]   cnt_q, cnt_d;
    logic [SEL_W-1:0] sel_d;
    logic             is_key, is_sel_wr, code_ok;

    always_comb begin
        is_key    = wr_en && (wr_data == ARM_KEY);
        is_sel_wr = wr_en && !wr_data[EN_BIT];
        code_ok   = (wr_data[SEL_W-1:0] <= CODE_MAX);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            cnt_q   <= '0;
            sel_q   <= strap_div8 ? CODE_STR : '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_d;
        end
    end

    // next state and register update
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (is_key) begin
                    state_d = ST_ARMED;
                    cnt_d   = '0;
                end
            end
            ST_ARMED: begin
                if (is_key) begin
                    cnt_d = '0;
                end else if (is_sel_wr) begin
                    state_d = ST_LOCKED;
                    if (code_ok) begin
                        sel_d = wr_data[SEL_W-1:0];
                    end
                end else if (cnt_q == LAST_CYC) begin
                    state_d = ST_LOCKED;
                end else begin
                    cnt_d = cnt_q + WCW'(1);
                end
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        window_open = (state_q == ST_ARMED);
    end

    AST_ARM_ONLY_BY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_open) |-> $past(wr_en && (wr_data == ARM_KEY))); // R4

    AST_COMMIT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (window_open && wr_en && !wr_data[EN_BIT]) |=> !window_open); // R5

    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(window_open) |-> $stable(sel_q)); // R7

    AST_RESERVED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (window_open && wr_en && !wr_data[EN_BIT] && (wr_data[SEL_W-1:0] > CODE_MAX))
        |=> ($stable(sel_q) && !window_open)); // R8

endmodule

// File: rtl/psc_divider.sv
module psc_divider
    import sysclk_prescaler_pkg::*;
#(
    parameter int MAX_CODE   = 8,
    parameter int STRAP_CODE = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_div8,
    input  logic [SEL_W-1:0] sel_target,
    output logic             sys_en
);

    localparam int CNT_W = (MAX_CODE > 0) ? MAX_CODE : 1;
    localparam logic [SEL_W-1:0] CODE_STR = SEL_W'(STRAP_CODE);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic [SEL_W-1:0] act_q;
    logic             period_end;

    always_comb begin
        limit      = CNT_W'((32'd1 << act_q) - 32'd1);
        period_end = (cnt_q == limit);
    end

    // counter and active-setting register; setting swaps only at period end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= strap_div8 ? CODE_STR : '0;
        end else if (period_end) begin
            cnt_q <= '0;
            act_q <= sel_target;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    always_comb begin
        sys_en = period_end;
    end

    AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sys_en) |-> $stable(act_q)); // R9

    AST_DIV1_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0) |-> sys_en); // R2

endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
    import sysclk_prescaler_pkg::*;
#(
    parameter int MAX_CODE   = 8,
    parameter int WIN        = 4,
    parameter int STRAP_CODE = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_div8,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sys_en
);

    localparam int PAD_W = REG_W - SEL_W - 1;

    logic             window_open;
    logic [SEL_W-1:0] sel_q;

    psc_unlock_fsm #(
        .MAX_CODE   (MAX_CODE),
        .WIN        (WIN),
        .STRAP_CODE (STRAP_CODE)
    ) u_unlock (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_div8  (strap_div8),
        .wr_en       (reg_wr),
        .wr_data     (reg_wdata),
        .window_open (window_open),
        .sel_q       (sel_q)
    );

    psc_divider #(
        .MAX_CODE   (MAX_CODE),
        .STRAP_CODE (STRAP_CODE)
    ) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_div8 (strap_div8),
        .sel_target (sel_q),
        .sys_en     (sys_en)
    );

    always_comb begin
        reg_rdata = {window_open, {PAD_W{1'b0}}, sel_q};
    end

    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-2:SEL_W] == '0); // R3

endmodule

// File: tb/sysclk_prescaler_test.sv
`timescale 1ns/1ps
module sysclk_prescaler_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strap_div8 = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sys_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    sysclk_prescaler uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap_div8 (strap_div8),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .sys_en     (sys_en)
    );

    // reference model built from the requirements
    logic [8:0] exp_q[$];
    int m_sel = 0, m_act = 0, m_dc = 0, m_wc = 0;
    bit m_open = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = strap_div8 ? 3 : 0;        // R1
            m_act = m_sel; m_dc = 0; m_open = 0; m_wc = 0;
        end else begin
            if (m_dc == (1 << m_act) - 1) begin m_dc = 0; m_act = m_sel; end // R9
            else m_dc++;
            if (!m_open) begin
                if (reg_wr && reg_wdata == 8'h80) begin m_open = 1; m_wc = 1; end // R4
            end else if (reg_wr && reg_wdata == 8'h80) begin
                m_wc = 1;                                   // R11
            end else if (reg_wr && !reg_wdata[7]) begin
                m_open = 0;
                if (reg_wdata[3:0] <= 8) m_sel = reg_wdata[3:0]; // R5 R8
            end else if (m_wc == 4) begin
                m_open = 0;                                 // R6
            end else m_wc++;
            exp_q.push_back({(m_dc == (1 << m_act) - 1), m_open, 3'b000, 4'(m_sel)});
        end
    end

    // monitor: pops expected items and compares
    int since = 0, last_gap = 0;
    always @(negedge clk) begin
        if (!rst_n) begin since = 0; end
        else begin
            since++;
            if (sys_en) begin last_gap = since; since = 0; end
        end
        if (exp_q.size() > 0) begin
            logic [8:0] e;
            e = exp_q.pop_front();
            n_cmp++;
            if (sys_en !== e[8]) begin
                n_bad++; $display("FAIL R2 R9 sys_en act=%0b exp=%0b t=%0t", sys_en, e[8], $time);
            end
            if (reg_rdata[7] !== e[7]) begin
                n_bad++; $display("FAIL R6 window bit act=%0b exp=%0b t=%0t", reg_rdata[7], e[7], $time);
            end
            if (reg_rdata[6:4] !== e[6:4]) begin
                n_bad++; $display("FAIL R3 pad bits act=%0h exp=%0h t=%0t", reg_rdata[6:4], e[6:4], $time);
            end
            if (reg_rdata[3:0] !== e[3:0]) begin
                n_bad++; $display("FAIL R5 select act=%0h exp=%0h t=%0t", reg_rdata[3:0], e[3:0], $time);
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // all driver tasks start and end at posedge+1
    task automatic wr(input logic [7:0] d);
        reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_wdata = 8'h00;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk); #1;
        rst_n = 1'b0; strap_div8 = strap;
        exp_q.delete();
        repeat (2) @(posedge clk);
        #1;
        check("R1 select in reset", reg_rdata, strap ? 3 : 0);
        rst_n = 1'b1;
    endtask

    task automatic gap_check(input string req, input int exp);
        do begin @(negedge clk); #1; end while (!sys_en);
        do begin @(negedge clk); #1; end while (!sys_en);
        check(req, last_gap, exp);
        @(posedge clk); #1;
    endtask

    initial begin
        do_reset(1'b0);
        idle(1);
        check("R1 rdata after reset", reg_rdata, 0);
        gap_check("R2 divide by 1", 1);

        wr(8'h05); idle(1);
        check("R7 locked select write", reg_rdata, 0);
        wr(8'h83); idle(1);
        check("R7 near-key write", reg_rdata, 0);

        wr(8'h80);
        check("R4 window opens", reg_rdata, 8'h80);
        idle(3); wr(8'h02);
        check("R5 cycle-4 write accepted", reg_rdata, 2);
        gap_check("R2 divide by 4", 4);

        wr(8'h80); idle(4); wr(8'h03);
        check("R6 cycle-5 write refused", reg_rdata, 2);

        wr(8'h80); wr(8'h0B);
        check("R8 reserved code dropped", reg_rdata, 2);

        wr(8'h80); idle(1); wr(8'hC1); idle(1); wr(8'h80); idle(3); wr(8'h08);
        check("R11 restart and near-key ignored", reg_rdata, 8);
        gap_check("R2 divide by 256", 256);

        wr(8'h80); wr(8'h71);
        check("R3 pad bits ignored", reg_rdata, 1);
        gap_check("R2 divide by 2", 2);

        wr(8'h80); wr(8'h04);
        gap_check("R2 divide by 16", 16);
        idle(5); wr(8'h80); wr(8'h01);
        do begin @(negedge clk); #1; end while (!sys_en);
        check("R9 spanning gap keeps old factor", last_gap, 16);
        do begin @(negedge clk); #1; end while (!sys_en);
        check("R9 next gap uses new factor", last_gap, 2);
        @(posedge clk); #1;

        do_reset(1'b1);
        idle(1);
        check("R1 strap reset value", reg_rdata, 3);
        gap_check("R2 strap divide by 8", 8);
        wr(8'h80); wr(8'h00);
        check("R10 code 0 after strap reset", reg_rdata, 0);
        gap_check("R10 divide by 1 restored", 1);

        idle(4);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule